// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block sits beside one processor port of a memory controller and keeps that processor's single address reservation. The processor sends one request per cycle: a reserving load, a conditional store, a plain store, or nothing. Each request carries a base value, a base register specifier and an index value, and the block forms the effective address from them. A reserving load records the 8-byte granule it touched. A conditional store is allowed to write only while the reservation still stands. Writes by other agents arrive on a snoop port, and one that lands in the reserved granule cancels the reservation.

One cycle after each request the block reports three things: whether the memory write may go ahead, whether a conditional store succeeded, and whether the access was misaligned. The current reservation flag is also visible as an output. The memory array and the coherence fabric are outside the block.

Top module: `resv_monitor`

## Requirements
- R1: Opcode 2'b10 (reserving load), when aligned, sets the reservation to the granule of its effective address. Any earlier reservation is replaced, so a snooped store to the old granule then has no effect.
- R2: Opcode 2'b11 (conditional store), when aligned, succeeds exactly when a reservation is held at that cycle. `sc_pass` and `wr_go` report the result one cycle later. The store's address is not compared with the reserved one.
- R3: A conditional store that fails leaves `wr_go` low, so memory is not written.
- R4: Every aligned conditional store clears the reservation, whether it succeeds or fails and whatever its address.
- R5: A snooped store clears the reservation when its address bits above bit 2 equal those of the reserved address. A snooped store to any other granule leaves the reservation unchanged.
- R6: If a snooped store hits the reserved granule in the same cycle as a conditional store, the conditional store fails.
- R7: Size bit 0 means a word and needs effective address bits [1:0] = 0. Size bit 1 means a doubleword and needs bits [2:0] = 0. A misaligned reserving load or conditional store raises `align_err` one cycle later, keeps `wr_go` and `sc_pass` low, and leaves the reservation unchanged.
- R8: The effective address is base + index, modulo 2^ADDR_W. The base counts as zero when the base register specifier is 0.
- R9: Opcode 2'b01 (own plain store) raises `wr_go` one cycle later and does not touch the reservation. Opcode 2'b00 does nothing.
- R10: After a synchronous active-low reset no reservation is held and `wr_go`, `sc_pass` and `align_err` are low.
- R11: A reserving load in the same cycle as a snoop hit on the old reservation leaves the new reservation set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | 00 idle, 01 plain store, 10 reserving load, 11 conditional store |
| req_dbl | input | 1 | Access size: 0 word, 1 doubleword |
| req_bsel | input | SEL_W | Base register specifier; 0 selects a zero base |
| req_base | input | ADDR_W | Base register value |
| req_index | input | ADDR_W | Index register value |
| snp_valid | input | 1 | A store by another agent is seen this cycle |
| snp_addr | input | ADDR_W | Address of the snooped store |
| wr_go | output | 1 | Registered: the memory write of the previous request may proceed |
| sc_pass | output | 1 | Registered: the previous conditional store succeeded |
| align_err | output | 1 | Registered: the previous reserving load or conditional store was misaligned |
| resv_held | output | 1 | A reservation is currently held |

## Verification
The bench builds the block with ADDR_W=16, SEL_W=5 and GRAN_BYTES=8. The narrow address makes it easy to drive a base plus index sum that wraps past the top of the address space, which exercises the modulo rule and granule matching near address zero. With 8-byte granules, snooped addresses can be placed inside the reserved granule but off its first byte, and just past its end, to probe the comparison boundary. The vectors also cover the same-cycle collisions of a snoop with a conditional store and with a reserving load.

// File: rtl/resv_pkg.sv
// Shared types for the reservation monitor.
// Assumes: the opcode encoding below is fixed by the processor port.
package resv_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_STORE = 2'b01,
        OP_LRES  = 2'b10,
        OP_SCOND = 2'b11
    } mem_op_e;
endpackage

// File: rtl/resv_agen.sv
// Effective address former and alignment check.
// Forms (base|0)+index modulo 2^ADDR_W and flags a size-misaligned result.
// Assumes: a zero specifier means "no base register".
module resv_agen #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 5
) (
    input  logic [SEL_W-1:0]  bsel,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic              dbl,
    output logic [ADDR_W-1:0] ea,
    output logic              aligned
);
    logic [ADDR_W-1:0] base_eff;

    // Select the zero base when the specifier is 0, then add the index.
    always_comb begin
        base_eff = (bsel == '0) ? '0 : base;
        ea       = base_eff + index;
    end

    // Word needs low two bits clear, doubleword needs low three clear.
    always_comb begin
        if (dbl) aligned = (ea[2:0] == 3'b000);
        else     aligned = (ea[1:0] == 2'b00);
    end
endmodule

// File: rtl/resv_track.sv
// Single-entry reservation register with snoop comparison.
// Holds one granule tag; a set request wins over any clear in the same cycle.
// Assumes: set_en and sc_clr are never high together (one request per cycle).
module resv_track #(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              sc_clr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              resv_valid,
    output logic              snoop_hit
);
    localparam int GL    = $clog2(GRAN_BYTES);
    localparam int TAG_W = ADDR_W - GL;

    logic [TAG_W-1:0] resv_tag;

    // Foreign store lands in the reserved granule.
    always_comb begin
        snoop_hit = resv_valid && snp_valid && (snp_addr[ADDR_W-1:GL] == resv_tag);
    end

    // Reservation state: set by reserving load, cleared by SC or snoop hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_valid <= 1'b0;
            resv_tag   <= '0;
        end else if (set_en) begin
            resv_valid <= 1'b1;
            resv_tag   <= set_addr[ADDR_W-1:GL];
        end else if (sc_clr || snoop_hit) begin
            resv_valid <= 1'b0;
        end
    end

    p_lr_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> resv_valid);
    p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && !set_en) |=> !resv_valid);
    p_snoop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !set_en) |=> !resv_valid);
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !sc_clr && !snp_valid) |=> $stable(resv_valid) && $stable(resv_tag));
endmodule

// File: rtl/resv_monitor.sv
// Per-processor load-reserve / store-conditional monitor (top).
// Decodes the request, drives the reservation tracker, and registers the
// write permission, conditional-store result and alignment error.
// Assumes: at most one processor request and one snooped store per cycle.
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SEL_W      = 5,
    parameter int GRAN_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_op,
    input  logic              req_dbl,
    input  logic [SEL_W-1:0]  req_bsel,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_index,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              wr_go,
    output logic              sc_pass,
    output logic              align_err,
    output logic              resv_held
);
    mem_op_e           op;
    logic [ADDR_W-1:0] ea;
    logic              aligned;
    logic              is_resv_op;
    logic              lr_go;
    logic              sc_go;
    logic              sc_ok;
    logic              snoop_hit;

    resv_agen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_agen (
        .bsel    (req_bsel),
        .base    (req_base),
        .index   (req_index),
        .dbl     (req_dbl),
        .ea      (ea),
        .aligned (aligned)
    );

    // Decode the request and qualify reservation ops by alignment.
    always_comb begin
        op         = mem_op_e'(req_op);
        is_resv_op = (op == OP_LRES) || (op == OP_SCOND);
        lr_go      = (op == OP_LRES)  && aligned;
        sc_go      = (op == OP_SCOND) && aligned;
        sc_ok      = sc_go && resv_held && !snoop_hit;
    end

    resv_track #(.ADDR_W(ADDR_W), .GRAN_BYTES(GRAN_BYTES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (lr_go),
        .set_addr   (ea),
        .sc_clr     (sc_go),
        .snp_valid  (snp_valid),
        .snp_addr   (snp_addr),
        .resv_valid (resv_held),
        .snoop_hit  (snoop_hit)
    );

    // Register the per-request response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_go     <= 1'b0;
            sc_pass   <= 1'b0;
            align_err <= 1'b0;
        end else begin
            wr_go     <= sc_ok || (op == OP_STORE);
            sc_pass   <= sc_ok;
            align_err <= is_resv_op && !aligned;
        end
    end

    p_sc_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> $past(resv_held));
    p_fail_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op == OP_SCOND) && !sc_pass) |-> !wr_go);
    p_collide_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_go && snoop_hit) |=> !sc_pass);
    p_misalign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!wr_go && !sc_pass));
    p_misalign_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_resv_op && !aligned && !snoop_hit) |=> $stable(resv_held));
    p_store_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_STORE) && !snp_valid) |=> (wr_go && $stable(resv_held)));
endmodule

// File: tb/tb_resv_monitor.sv
// Self-checking bench: vector table walk, then directed reset checks.
module tb_resv_monitor;
    localparam int AW = 16;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic          req_dbl = 1'b0;
    logic [SW-1:0] req_bsel = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_index = '0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          wr_go, sc_pass, align_err, resv_held;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk; // 50 MHz

    resv_monitor #(.ADDR_W(AW), .SEL_W(SW), .GRAN_BYTES(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_dbl(req_dbl),
        .req_bsel(req_bsel), .req_base(req_base), .req_index(req_index),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .wr_go(wr_go), .sc_pass(sc_pass), .align_err(align_err),
        .resv_held(resv_held)
    );

    typedef struct packed {
        logic [1:0]    op;
        logic          dbl;
        logic [SW-1:0] bsel;
        logic [AW-1:0] base;
        logic [AW-1:0] idx;
        logic          sv;
        logic [AW-1:0] sa;
        logic          e_err;
        logic          e_wr;
        logic          e_sc;
        logic          e_rv;
    } vec_t;

    localparam int NV = 26;
    // op: 00 idle, 01 store, 10 reserving load, 11 conditional store
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b11,1'b0,5'd0,16'h0000,16'h0100,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0}, // R2 R3 SC without reservation
        '{2'b10,1'b1,5'd3,16'h1000,16'h0020,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R1 R8 LR at 0x1020
        '{2'b01,1'b0,5'd3,16'h1000,16'h0020,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1}, // R9 own store keeps
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R9 idle
        '{2'b11,1'b1,5'd3,16'h1000,16'h0020,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b0}, // R2 R4 SC succeeds, clears
        '{2'b11,1'b1,5'd3,16'h1000,16'h0020,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0}, // R3 R4 second SC fails
        '{2'b10,1'b0,5'd0,16'hFFFF,16'h2004,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R8 zero base -> 0x2004
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h2008,1'b0,1'b0,1'b0,1'b1}, // R5 next granule, kept
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h1FFF,1'b0,1'b0,1'b0,1'b1}, // R5 previous granule, kept
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h2007,1'b0,1'b0,1'b0,1'b0}, // R5 same granule clears
        '{2'b11,1'b0,5'd0,16'h0000,16'h2004,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0}, // R3 SC after snoop fails
        '{2'b10,1'b0,5'd1,16'h3000,16'h0008,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R1 LR 0x3008
        '{2'b10,1'b1,5'd1,16'h4000,16'h0004,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1}, // R7 misaligned dbl LR
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h4000,1'b0,1'b0,1'b0,1'b1}, // R7 old granule still held
        '{2'b11,1'b0,5'd2,16'h3000,16'h0002,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1}, // R7 misaligned word SC
        '{2'b11,1'b0,5'd0,16'h0000,16'h0500,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b0}, // R2 R4 SC any address
        '{2'b10,1'b0,5'd0,16'h0000,16'h3008,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R1 LR 0x3008
        '{2'b11,1'b0,5'd0,16'h0000,16'h300C,1'b1,16'h3008,1'b0,1'b0,1'b0,1'b0}, // R6 snoop wins
        '{2'b10,1'b1,5'd0,16'h0000,16'h3010,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R1 LR 0x3010
        '{2'b10,1'b0,5'd0,16'h0000,16'h5000,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R1 replace with 0x5000
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h3010,1'b0,1'b0,1'b0,1'b1}, // R1 old granule ignored
        '{2'b11,1'b0,5'd0,16'h0000,16'h5000,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b0}, // R2 SC succeeds
        '{2'b10,1'b1,5'd2,16'hFFF8,16'h0010,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R8 wrap -> 0x0008
        '{2'b00,1'b0,5'd0,16'h0000,16'h0000,1'b1,16'h000C,1'b0,1'b0,1'b0,1'b0}, // R8 R5 wrapped granule hit
        '{2'b10,1'b0,5'd0,16'h0000,16'h0008,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1}, // R11 reserve 0x0008 again
        '{2'b10,1'b0,5'd0,16'h0000,16'h0010,1'b1,16'h0008,1'b0,1'b0,1'b0,1'b1}  // R11 LR beats snoop hit
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic drive_idle();
        req_op = 2'b00; req_dbl = 1'b0; req_bsel = '0;
        req_base = '0; req_index = '0; snp_valid = 1'b0; snp_addr = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 resv_held", resv_held, 1'b0);
        chk("R10 wr_go", wr_go, 1'b0);
        chk("R10 sc_pass", sc_pass, 1'b0);
        chk("R10 align_err", align_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            req_op = VECS[i].op; req_dbl = VECS[i].dbl; req_bsel = VECS[i].bsel;
            req_base = VECS[i].base; req_index = VECS[i].idx;
            snp_valid = VECS[i].sv; snp_addr = VECS[i].sa;
            @(negedge clk);
            $display("vector %0d", i);
            chk("R7 align_err", align_err, VECS[i].e_err);
            chk("R3 R9 wr_go", wr_go, VECS[i].e_wr);
            chk("R2 sc_pass", sc_pass, VECS[i].e_sc);
            chk("R1 R4 R5 resv_held", resv_held, VECS[i].e_rv);
        end

        // R10 reset in the middle of a held reservation and a pending store
        drive_idle();
        req_op = 2'b01;
        @(negedge clk);
        chk("R9 wr_go before reset", wr_go, 1'b1);
        chk("R10 reservation before reset", resv_held, 1'b1);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 resv cleared", resv_held, 1'b0);
        chk("R10 wr_go cleared", wr_go, 1'b0);
        rst_n = 1'b1;
        // R2 SC right after reset fails
        req_op = 2'b11; req_index = 16'h0008;
        @(negedge clk);
        chk("R2 SC after reset", sc_pass, 1'b0);
        chk("R3 no write after reset", wr_go, 1'b0);
        drive_idle();
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule